// File: doc/BRIEF.md
# Prioritized Shared-Pin Port Multiplexer

This block arbitrates one bidirectional pin port between a pulse-width modulator, a set of serial-peripheral engines and plain general-purpose I/O. Ownership is decided per pin, from a fixed priority over the peripheral enable signals. The modulator wins over everything. A serial engine owns its own group of pins only while the modulator is off. A pin that no peripheral claims falls back to the GPIO data and direction registers. For each pin the block produces the pad output value and the pad output enable, and it routes the synchronized pad value back to whichever peripheral owns that pin.

The modulator drives every pin it owns as an output, with one exception: the top pin may also serve as a modulator input. That pin's direction comes from a separate modulator control. While a serial engine owns a pin, the engine's own per-pin status sets both drive value and direction, and no port register is involved.

Every pad input passes through a synchronizer. The synchronized value is always readable, whoever owns the pin. A per-pin edge detector sets a sticky flag on the edge that the polarity bit selects, and it keeps running while a peripheral owns the pin. A flag is cleared by writing 1 to it. The flags, masked by their enables, are ORed into one interrupt request.

Top module: `pinshare_port`

## Requirements
- R1: When pwm_en is 0 and the serial engine of a pin's group is disabled, pad_oe of that pin equals gpio_dir and pad_out of that pin equals gpio_data.
- R2: When pwm_en is 1, the modulator owns all pins whatever spi_en holds, and pins 0 to PINS-2 have pad_oe 1 and pad_out equal to pwm_out.
- R3: When the modulator owns the port, the top pin has pad_out equal to pwm_out and pad_oe equal to pwm_pin_dir (1 means drive). pwm_in carries that pin's synchronized value when the modulator owns the port and pwm_pin_dir is 0. Otherwise pwm_in is 0.
- R4: With pwm_en at 0, spi_en[g] gives serial engine g the pins g*GROUP to g*GROUP+GROUP-1 (engine 0 has pins 0 to 3, engine 1 has pins 4 to 7). On those pins pad_oe equals spi_oe and pad_out equals spi_do. The other group is unaffected.
- R5: spi_in of a pin carries the synchronized pad value while a serial engine owns that pin, and 0 otherwise.
- R6: port_in shows pad_in through a two-flop synchronizer. A pad change sampled at clock edge k is visible after edge k+1, whoever owns the pin.
- R7: irq_flag of a pin is set by a rising synchronized edge when irq_pol is 1, and by a falling one when irq_pol is 0. The opposite edge has no effect. A pad change sampled at edge k sets the flag at edge k+2.
- R8: A 1 in flag_clr clears that flag at the next edge and a 0 leaves it alone. A set and a clear in the same cycle leave the flag set.
- R9: irq_req is the OR over all pins of irq_flag AND irq_en. Flags are set even when their enable is 0.
- R10: Reset clears all flags and port_in. No edge is detected until the synchronizer and edge-history stages hold real samples, so a pad held high through reset raises no flag.
- R11: Edge detection and flag setting work on pins owned by the modulator or a serial engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_en | input | 1 | Modulator enable, highest ownership priority |
| pwm_out | input | PINS | Modulator channel outputs |
| pwm_pin_dir | input | 1 | Top-pin direction under modulator ownership, 1 = drive |
| spi_en | input | SPI_COUNT | Serial engine enables, one per pin group |
| spi_do | input | PINS | Serial engine per-pin drive value |
| spi_oe | input | PINS | Serial engine per-pin direction status, 1 = drive |
| gpio_data | input | PINS | GPIO output data register |
| gpio_dir | input | PINS | GPIO direction register, 1 = drive |
| irq_en | input | PINS | Per-pin interrupt enable |
| irq_pol | input | PINS | Edge select, 1 = rising, 0 = falling |
| flag_clr | input | PINS | Write-1-to-clear pulses for the flags |
| pad_in | input | PINS | Raw pad input values |
| pad_out | output | PINS | Pad output values |
| pad_oe | output | PINS | Pad output enables |
| port_in | output | PINS | Synchronized pad values |
| pwm_in | output | 1 | Top-pin input routed to the modulator |
| spi_in | output | PINS | Per-pin input routed to the serial engines |
| irq_flag | output | PINS | Sticky edge flags |
| irq_req | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its defaults: eight pins, two serial groups of four and two synchronizer stages. These are the values under which the fixed group mapping and the two-cycle input latency hold. With them, a single run reaches the modulator-over-serial priority, both groups enabled together and separately, both directions of the bidirectional top pin, and edges on pins of every owner. The bench also times a clear pulse onto the exact edge where a flag sets, and it holds a pad high through reset release.

// File: rtl/pinshare_pkg.sv
package pinshare_pkg;

   // Who drives a pin this cycle, in falling priority.
   typedef enum logic [1:0] {
      OWN_GPIO = 2'd0,
      OWN_SPI  = 2'd1,
      OWN_PWM  = 2'd2
   } owner_e;

endpackage

// File: rtl/pinshare_owner.sv
module pinshare_owner
   import pinshare_pkg::*;
#(
   parameter int PINS      = 8,
   parameter int SPI_COUNT = 2
) (
   input  logic                 pwm_en,
   input  logic [SPI_COUNT-1:0] spi_en,
   output owner_e               owner [PINS]
);

   localparam int GROUP = PINS / SPI_COUNT;

   for (genvar p = 0; p < PINS; p++) begin : g_pin
      localparam int GRP_IDX = p / GROUP;
      always_comb begin
         if (pwm_en)
            owner[p] = OWN_PWM;
         else if (spi_en[GRP_IDX])
            owner[p] = OWN_SPI;
         else
            owner[p] = OWN_GPIO;
      end
   end

endmodule

// File: rtl/pinshare_pinmux.sv
module pinshare_pinmux
   import pinshare_pkg::*;
#(
   parameter int PINS      = 8,
   parameter int BIDIR_PIN = PINS - 1
) (
   input  owner_e            owner [PINS],
   input  logic [PINS-1:0]   pwm_out,
   input  logic              pwm_pin_dir,
   input  logic [PINS-1:0]   spi_do,
   input  logic [PINS-1:0]   spi_oe,
   input  logic [PINS-1:0]   gpio_data,
   input  logic [PINS-1:0]   gpio_dir,
   input  logic [PINS-1:0]   pin_sync,
   output logic [PINS-1:0]   pad_out,
   output logic [PINS-1:0]   pad_oe,
   output logic [PINS-1:0]   spi_in,
   output logic              pwm_in
);

   for (genvar p = 0; p < PINS; p++) begin : g_pin
      logic pwm_drive;

      // Only one pin may be turned around by the modulator.
      if (p == BIDIR_PIN) begin : g_bidir
         assign pwm_drive = pwm_pin_dir;
      end else begin : g_outonly
         assign pwm_drive = 1'b1;
      end

      always_comb begin
         unique case (owner[p])
            OWN_PWM: begin
               pad_out[p] = pwm_out[p];
               pad_oe[p]  = pwm_drive;
            end
            OWN_SPI: begin
               pad_out[p] = spi_do[p];
               pad_oe[p]  = spi_oe[p];
            end
            default: begin
               pad_out[p] = gpio_data[p];
               pad_oe[p]  = gpio_dir[p];
            end
         endcase
         spi_in[p] = (owner[p] == OWN_SPI) ? pin_sync[p] : 1'b0;
      end
   end

   assign pwm_in = (owner[BIDIR_PIN] == OWN_PWM) && !pwm_pin_dir
                   ? pin_sync[BIDIR_PIN] : 1'b0;

endmodule

// File: rtl/pinshare_edge.sv
module pinshare_edge #(
   parameter int PINS        = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PINS-1:0] pad_in,
   input  logic [PINS-1:0] irq_pol,
   input  logic [PINS-1:0] flag_clr,
   output logic [PINS-1:0] pin_sync,
   output logic [PINS-1:0] flags
);

   localparam int LAST = SYNC_STAGES - 1;

   logic [PINS-1:0]      stage [SYNC_STAGES];
   logic [PINS-1:0]      hist;
   logic [SYNC_STAGES:0] fill;
   logic [PINS-1:0]      hit;

   assign pin_sync = stage[LAST];

   // An edge counts only once the history stage holds a real sample.
   always_comb begin
      if (fill[SYNC_STAGES])
         hit = (pin_sync & ~hist & irq_pol) | (~pin_sync & hist & ~irq_pol);
      else
         hit = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SYNC_STAGES; s++) stage[s] <= '0;
         hist  <= '0;
         fill  <= '0;
         flags <= '0;
      end else begin
         stage[0] <= pad_in;
         for (int s = 1; s < SYNC_STAGES; s++) stage[s] <= stage[s-1];
         hist  <= stage[LAST];
         fill  <= {fill[SYNC_STAGES-1:0], 1'b1};
         // A new edge outranks a clear in the same cycle.
         flags <= (flags & ~flag_clr) | hit;
      end
   end

endmodule

// File: rtl/pinshare_port.sv
module pinshare_port
   import pinshare_pkg::*;
#(
   parameter int PINS        = 8,
   parameter int SPI_COUNT   = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pwm_en,
   input  logic [PINS-1:0]      pwm_out,
   input  logic                 pwm_pin_dir,
   input  logic [SPI_COUNT-1:0] spi_en,
   input  logic [PINS-1:0]      spi_do,
   input  logic [PINS-1:0]      spi_oe,
   input  logic [PINS-1:0]      gpio_data,
   input  logic [PINS-1:0]      gpio_dir,
   input  logic [PINS-1:0]      irq_en,
   input  logic [PINS-1:0]      irq_pol,
   input  logic [PINS-1:0]      flag_clr,
   input  logic [PINS-1:0]      pad_in,
   output logic [PINS-1:0]      pad_out,
   output logic [PINS-1:0]      pad_oe,
   output logic [PINS-1:0]      port_in,
   output logic                 pwm_in,
   output logic [PINS-1:0]      spi_in,
   output logic [PINS-1:0]      irq_flag,
   output logic                 irq_req
);

   localparam int BIDIR_PIN = PINS - 1;

   if (SPI_COUNT < 1 || PINS % SPI_COUNT != 0) begin : g_bad_groups
      $error("PINS must split evenly into SPI_COUNT groups");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (PINS < 2) begin : g_bad_pins
      $error("PINS must be at least 2");
   end

   owner_e          owner [PINS];
   logic [PINS-1:0] pin_sync;
   logic [PINS-1:0] flags;

   pinshare_owner #(
      .PINS      (PINS),
      .SPI_COUNT (SPI_COUNT)
   ) u_owner (
      .pwm_en (pwm_en),
      .spi_en (spi_en),
      .owner  (owner)
   );

   pinshare_edge #(
      .PINS        (PINS),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .pad_in   (pad_in),
      .irq_pol  (irq_pol),
      .flag_clr (flag_clr),
      .pin_sync (pin_sync),
      .flags    (flags)
   );

   pinshare_pinmux #(
      .PINS      (PINS),
      .BIDIR_PIN (BIDIR_PIN)
   ) u_mux (
      .owner       (owner),
      .pwm_out     (pwm_out),
      .pwm_pin_dir (pwm_pin_dir),
      .spi_do      (spi_do),
      .spi_oe      (spi_oe),
      .gpio_data   (gpio_data),
      .gpio_dir    (gpio_dir),
      .pin_sync    (pin_sync),
      .pad_out     (pad_out),
      .pad_oe      (pad_oe),
      .spi_in      (spi_in),
      .pwm_in      (pwm_in)
   );

   assign port_in  = pin_sync;
   assign irq_flag = flags;
   assign irq_req  = |(flags & irq_en);

endmodule

// File: rtl/pinshare_port_chk.sv
module pinshare_port_chk #(
   parameter int PINS  = 8,
   parameter int GROUP = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            pwm_en,
   input logic            pwm_pin_dir,
   input logic            spi_en0,
   input logic [PINS-1:0] spi_oe,
   input logic [PINS-1:0] pad_oe,
   input logic [PINS-1:0] port_in,
   input logic [PINS-1:0] irq_flag,
   input logic [PINS-1:0] irq_pol,
   input logic [PINS-1:0] flag_clr
);

   // R2
   pwm_drives_low_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_en |-> (&pad_oe[PINS-2:0]));

   // R3
   bidir_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_en && !pwm_pin_dir) |-> !pad_oe[PINS-1]);

   // R4
   spi_group0_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwm_en && spi_en0) |-> (pad_oe[GROUP-1:0] == spi_oe[GROUP-1:0]));

   // R7
   flag_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_flag & ~$past(irq_flag)) & ~($past(port_in) ^ $past(port_in, 2))) == '0);

   // R7
   flag_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_flag & ~$past(irq_flag)) & ($past(port_in) ^ $past(irq_pol))) == '0);

   // R8
   clear_wins_unless_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag & $past(flag_clr) & ~($past(port_in) ^ $past(port_in, 2))) == '0);

endmodule

bind pinshare_port pinshare_port_chk #(
   .PINS  (PINS),
   .GROUP (PINS / SPI_COUNT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pwm_en      (pwm_en),
   .pwm_pin_dir (pwm_pin_dir),
   .spi_en0     (spi_en[0]),
   .spi_oe      (spi_oe),
   .pad_oe      (pad_oe),
   .port_in     (port_in),
   .irq_flag    (irq_flag),
   .irq_pol     (irq_pol),
   .flag_clr    (flag_clr)
);

// File: tb/test_pinshare_port.sv
`timescale 1ns/1ps
module test_pinshare_port;

   localparam int PINS  = 8;
   localparam int NSPI  = 2;
   localparam int GRP   = PINS / NSPI;
   localparam int S     = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            pwm_en = 1'b0;
   logic [PINS-1:0] pwm_out = '0;
   logic            pwm_pin_dir = 1'b0;
   logic [NSPI-1:0] spi_en = '0;
   logic [PINS-1:0] spi_do = '0, spi_oe = '0;
   logic [PINS-1:0] gpio_data = '0, gpio_dir = '0;
   logic [PINS-1:0] irq_en = '0, irq_pol = '0, flag_clr = '0, pad_in = '0;
   logic [PINS-1:0] pad_out, pad_oe, port_in, spi_in, irq_flag;
   logic            pwm_in, irq_req;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   pinshare_port #(.PINS(PINS), .SPI_COUNT(NSPI), .SYNC_STAGES(S)) i_pinshare_port (
      .clk(clk), .rst_n(rst_n), .pwm_en(pwm_en), .pwm_out(pwm_out),
      .pwm_pin_dir(pwm_pin_dir), .spi_en(spi_en), .spi_do(spi_do), .spi_oe(spi_oe),
      .gpio_data(gpio_data), .gpio_dir(gpio_dir), .irq_en(irq_en), .irq_pol(irq_pol),
      .flag_clr(flag_clr), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
      .port_in(port_in), .pwm_in(pwm_in), .spi_in(spi_in), .irq_flag(irq_flag),
      .irq_req(irq_req));

   // Behavioural reference: a short history of sampled pad values and a flag word.
   logic [PINS-1:0] m_hist [$];
   logic [PINS-1:0] m_flag = '0;

   always @(posedge clk) begin
      logic [PINS-1:0] hit;
      hit = '0;
      if (!rst_n) begin
         m_hist.delete();
         m_flag = '0;
      end else begin
         if (m_hist.size() >= S + 1) begin
            logic [PINS-1:0] now_v, old_v;
            now_v = m_hist[m_hist.size() - S];
            old_v = m_hist[m_hist.size() - S - 1];
            for (int i = 0; i < PINS; i++) begin
               if (irq_pol[i] ? (now_v[i] && !old_v[i]) : (!now_v[i] && old_v[i]))
                  hit[i] = 1'b1;
            end
         end
         m_flag = (m_flag & ~flag_clr) | hit;
         m_hist.push_back(pad_in);
         if (m_hist.size() > S + 1) void'(m_hist.pop_front());
      end
   end

   function automatic logic [PINS-1:0] exp_sync();
      return (m_hist.size() >= S) ? m_hist[m_hist.size() - S] : '0;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // Compare every output with the reference on each falling edge.
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         logic [PINS-1:0] e_out, e_oe, e_spi, sy;
         logic            e_pwm;
         string           tag;
         sy = exp_sync();
         e_spi = '0;
         for (int i = 0; i < PINS; i++) begin
            if (pwm_en) begin
               e_out[i] = pwm_out[i];
               e_oe[i]  = (i == PINS - 1) ? pwm_pin_dir : 1'b1;
            end else if (spi_en[i / GRP]) begin
               e_out[i] = spi_do[i];
               e_oe[i]  = spi_oe[i];
               e_spi[i] = sy[i];
            end else begin
               e_out[i] = gpio_data[i];
               e_oe[i]  = gpio_dir[i];
            end
         end
         e_pwm = (pwm_en && !pwm_pin_dir) ? sy[PINS-1] : 1'b0;
         tag = pwm_en ? "R2/R3" : (spi_en != 0 ? "R4" : "R1");
         check({tag, " pad_out"}, 32'(pad_out), 32'(e_out));
         check({tag, " pad_oe"}, 32'(pad_oe), 32'(e_oe));
         check("R5 spi_in", 32'(spi_in), 32'(e_spi));
         check("R3 pwm_in", 32'(pwm_in), 32'(e_pwm));
         check("R6 port_in", 32'(port_in), 32'(sy));
         check("R7 irq_flag", 32'(irq_flag), 32'(m_flag));
         check("R9 irq_req", 32'(irq_req), 32'(|(m_flag & irq_en)));
      end
   end

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic pulse_clear(logic [PINS-1:0] v);
      flag_clr = v;
      step(1);
      flag_clr = '0;
   endtask

   initial begin
      step(1);
      #0.5;
      // R10: state held in reset
      check("R10 reset irq_flag", 32'(irq_flag), 32'h0);
      check("R10 reset port_in", 32'(port_in), 32'h0);
      step(3);
      rst_n = 1'b1;
      step(4);

      // R1: GPIO ownership with two patterns
      gpio_dir = 8'hA5; gpio_data = 8'h3C; step(3);
      gpio_dir = 8'h5A; gpio_data = 8'hC3; step(3);

      // R2 / R3: modulator wins over both serial engines
      pwm_en = 1'b1; spi_en = 2'b11; pwm_out = 8'h5A; pwm_pin_dir = 1'b1;
      spi_oe = 8'h00; step(3);
      pwm_out = 8'hA5; step(2);
      pwm_pin_dir = 1'b0; irq_pol = 8'h80; pad_in = 8'h80; step(4);
      // R11: edge on the modulator's input pin raised a flag
      check("R11 flag under modulator", 32'(irq_flag[7]), 32'h1);
      pad_in = 8'h00; irq_pol = 8'h00; step(4);
      pulse_clear(8'h80); step(1);
      // R8: write-1 clear
      check("R8 clear", 32'(irq_flag[7]), 32'h0);

      // R4 / R5: serial groups alone and together
      pwm_en = 1'b0; spi_en = 2'b01; spi_oe = 8'h0B; spi_do = 8'hF0; step(3);
      spi_en = 2'b10; spi_oe = 8'hB0; spi_do = 8'h0F; step(3);
      spi_en = 2'b11; spi_oe = 8'h9C; pad_in = 8'h96; step(4);
      pad_in = 8'h00; step(4);

      // R7 / R9: rising on low half, falling on high half
      spi_en = 2'b00; irq_pol = 8'h0F; irq_en = 8'h03;
      pulse_clear(8'hFF); step(1);
      pad_in = 8'hFF; step(4);
      check("R7 rising half", 32'(irq_flag), 32'h0F);
      pad_in = 8'h00; step(4);
      check("R7 falling half", 32'(irq_flag), 32'hFF);
      check("R9 request", 32'(irq_req), 32'h1);
      irq_en = 8'h00; step(1);
      check("R9 masked", 32'(irq_req), 32'h0);

      // R8: set and clear on the same edge keep the flag
      pulse_clear(8'hFF); step(1);
      irq_pol = 8'h01; pad_in = 8'h01; step(2);
      flag_clr = 8'h01; step(1); flag_clr = '0;
      check("R8 set beats clear", 32'(irq_flag[0]), 32'h1);
      step(2);

      // R10: pad held high across reset release raises nothing
      rst_n = 1'b0; pad_in = 8'hFF; irq_pol = 8'hFF; step(2);
      rst_n = 1'b1; step(6);
      check("R10 no flag after reset", 32'(irq_flag), 32'h0);
      check("R6 port_in after reset", 32'(port_in), 32'hFF);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule